// File: doc/BRIEF.md
# Repeated-Copy Majority Byte Extractor

This block recovers a table of calibration bytes from a parameter area that was written to storage as many redundant copies. Some copies are stored plain and some are stored bit-inverted. The block reads the area through a synchronous read port with one cycle of latency. It gathers the eight copies of each field into local registers and votes on them.

The block first recovers two header values: how many modes the table has and how many registers each mode has. It then recovers every table entry, in mode-major order. For each entry it votes over the plain copies first. If that vote fails, it votes over the inverted copies and writes the complement of the winner. Each recovered entry goes out on a write port, one strobe per entry. The run ends with a one-cycle `done` pulse. If a header or an entry cannot be recovered, the run ends instead with a one-cycle `fail` pulse.

Top module: `rcopy_vote_extract`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `fail`, `tbl_we` and `mem_re` are all 0.
- R2: A `start` pulse in the idle state begins a run.
  - The block reads the mode-count copies from bytes 0..7, in increasing address order.
  - It then reads the register-count copies from bytes 8..15.
  - The voted results appear on `mode_count` and `reg_count`.
- R3: A vote over 8 copies works as follows.
  - Only copies 0..3 are candidates.
  - A candidate wins when more than 4 of the copies after it hold the same byte.
  - The lowest-numbered winner is taken.
  - As a result, a value held by 6 or more copies is accepted, and a value held by 5 or fewer is rejected.
- R4: Let S = mode_count × reg_count.
  - The plain copy c of entry e is at byte 16 + 2·c·S + e.
  - The inverted copy c of entry e is at byte 16 + (2·c+1)·S + e.
  - Entry e = m·reg_count + j belongs to mode m and register j.
- R5: When the plain vote for an entry fails and the inverted vote succeeds, the written byte is the bitwise complement of the inverted winner.
- R6: When both votes for an entry fail, the block pulses `fail` and stops. Entries written earlier stay written, and no later entry is written.
- R7: When either header vote fails, the block pulses `fail` without reading or writing any table entry. A failed mode-count vote ends the run after 8 reads.
- R8: Each recovered entry is written with exactly one `tbl_we` pulse. The first write of a run goes to `tbl_addr` 0 and each later write goes to the next address.
- R9: A successful run ends with `done` high for exactly one cycle, in the same cycle as the last table write. `done` and `fail` are never high together.
- R10: When either header count is 0, the run ends with `done` and no table writes.
- R11: `mem_re` is asserted only while `busy` is high. Read data is taken one cycle after the read strobe. Every read address lies inside the layout of R4.
- R12: A `start` pulse while a run is in progress, or in the `done` or `fail` cycle, has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (honoured only when idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: all entries recovered |
| fail | output | 1 | One-cycle pulse: a header or an entry could not be recovered |
| mem_re | output | 1 | Buffer read strobe |
| mem_addr | output | AW (21) | Buffer byte address |
| mem_rdata | input | DW (8) | Read data, valid one cycle after `mem_re` |
| tbl_we | output | 1 | Table write strobe, one per entry |
| tbl_addr | output | TW (16) | Entry index, mode-major |
| tbl_data | output | DW (8) | Recovered entry byte |
| mode_count | output | DW (8) | Voted mode count |
| reg_count | output | DW (8) | Voted register count |

## Verification
The assertions assume three things about the inputs.
- The buffer answers every strobe with data one cycle later.
- `start` is not raised again before a run has finished, unless the aim is to show that it is ignored.
- The product of the two header counts fits in `tbl_addr`.

The bench keeps within these assumptions in the following ways.
- Its memory model is a registered array that answers every strobe.
- It limits the table to at most 12 entries, so that every copy lies inside a 256-byte buffer.
- It raises `start` mid-run only in the case that tests R12.

The corruption patterns are chosen on purpose:
- they place disagreeing copies at the head or the tail of the eight copies;
- every corrupted byte is distinct, so no accidental majority can form.

// File: rtl/rcv_pkg.sv
package rcv_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_HDR_M,
      ST_HDR_R,
      ST_SETUP,
      ST_ISSUE,
      ST_PLAIN,
      ST_INV,
      ST_DONE,
      ST_FAIL
   } rcv_state_e;

endpackage

// File: rtl/rcv_gather.sv
// Issues COPIES strided reads and collects the returned bytes.
module rcv_gather #(
   parameter int DW     = 8,
   parameter int AW     = 21,
   parameter int COPIES = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          go,
   input  logic [AW-1:0]                 base,
   input  logic [AW-1:0]                 stride,
   output logic                          mem_re,
   output logic [AW-1:0]                 mem_addr,
   input  logic [DW-1:0]                 mem_rdata,
   output logic [COPIES-1:0][DW-1:0]     copies,
   output logic                          filled
);
   localparam int CW = (COPIES > 1) ? $clog2(COPIES) : 1;
   localparam logic [CW-1:0] LAST = CW'(COPIES - 1);

   logic          active_q;
   logic [CW-1:0] iss_q;
   logic [AW-1:0] addr_q;
   logic [AW-1:0] stride_q;
   logic          pend_q;
   logic [CW-1:0] pidx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         iss_q    <= '0;
         addr_q   <= '0;
         stride_q <= '0;
         pend_q   <= 1'b0;
         pidx_q   <= '0;
         copies   <= '0;
         filled   <= 1'b0;
      end else begin
         if (go) begin
            active_q <= 1'b1;
            iss_q    <= '0;
            addr_q   <= base;
            stride_q <= stride;
         end else if (active_q) begin
            addr_q <= addr_q + stride_q;
            iss_q  <= iss_q + CW'(1);
            if (iss_q == LAST) begin
               active_q <= 1'b0;
            end
         end
         pend_q <= active_q;
         pidx_q <= iss_q;
         if (pend_q) begin
            copies[pidx_q] <= mem_rdata;
         end
         filled <= pend_q && (pidx_q == LAST);
      end
   end

   assign mem_re   = active_q;
   assign mem_addr = addr_q;

endmodule

// File: rtl/rcv_vote.sv
// Combinational vote: a candidate from the first half wins with more than
// HALF matching later copies; lowest index has priority.
module rcv_vote #(
   parameter int DW     = 8,
   parameter int COPIES = 8
) (
   input  logic [COPIES-1:0][DW-1:0] copies,
   output logic                      ok,
   output logic [DW-1:0]             value
);
   localparam int HALF = COPIES / 2;
   localparam int NW   = $clog2(COPIES + 1);

   logic [HALF-1:0] win;

   for (genvar gi = 0; gi < HALF; gi++) begin : g_cand
      logic [NW-1:0] cnt;
      always_comb begin
         cnt = '0;
         for (int j = gi + 1; j < COPIES; j++) begin
            if (copies[j] == copies[gi]) begin
               cnt = cnt + NW'(1);
            end
         end
      end
      assign win[gi] = (cnt > NW'(HALF));
   end

   always_comb begin
      ok    = 1'b0;
      value = '0;
      for (int i = HALF - 1; i >= 0; i--) begin
         if (win[i]) begin
            ok    = 1'b1;
            value = copies[i];
         end
      end
   end

endmodule

// File: rtl/rcopy_vote_extract.sv
module rcopy_vote_extract
   import rcv_pkg::*;
#(
   parameter int DW     = 8,
   parameter int AW     = 21,
   parameter int TW     = 16,
   parameter int COPIES = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic          done,
   output logic          fail,
   output logic          mem_re,
   output logic [AW-1:0] mem_addr,
   input  logic [DW-1:0] mem_rdata,
   output logic          tbl_we,
   output logic [TW-1:0] tbl_addr,
   output logic [DW-1:0] tbl_data,
   output logic [DW-1:0] mode_count,
   output logic [DW-1:0] reg_count
);
   localparam int HDR_OFS = 2 * COPIES;
   localparam int SPAN_W  = $clog2(2 * COPIES);

   if (COPIES < 2 || (COPIES % 2) != 0) begin : g_bad_copies
      $error("COPIES must be even and at least 2");
   end
   if (TW < 2 * DW) begin : g_bad_tw
      $error("TW must hold the product of two DW-bit counts");
   end
   if (AW < TW + SPAN_W + 1) begin : g_bad_aw
      $error("AW too narrow for the copy layout");
   end

   rcv_state_e st_q, st_n;

   logic [DW-1:0] nm_q, nr_q;
   logic [TW-1:0] set_q, off_q;

   logic          g_go;
   logic [AW-1:0] g_base, g_stride;
   logic [COPIES-1:0][DW-1:0] g_copies;
   logic          g_filled;
   logic          v_ok;
   logic [DW-1:0] v_val;

   logic          wr;
   logic [DW-1:0] wr_data;
   logic          last_ent;

   rcv_gather #(.DW(DW), .AW(AW), .COPIES(COPIES)) u_gather (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (g_go),
      .base      (g_base),
      .stride    (g_stride),
      .mem_re    (mem_re),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata),
      .copies    (g_copies),
      .filled    (g_filled)
   );

   rcv_vote #(.DW(DW), .COPIES(COPIES)) u_vote (
      .copies (g_copies),
      .ok     (v_ok),
      .value  (v_val)
   );

   assign last_ent = (off_q == set_q - TW'(1));

   always_comb begin
      st_n     = st_q;
      g_go     = 1'b0;
      g_base   = '0;
      g_stride = AW'(1);
      wr       = 1'b0;
      wr_data  = v_val;
      case (st_q)
         ST_IDLE: begin
            if (start) begin
               g_go = 1'b1;
               st_n = ST_HDR_M;
            end
         end
         ST_HDR_M: begin
            if (g_filled) begin
               if (v_ok) begin
                  g_go   = 1'b1;
                  g_base = AW'(COPIES);
                  st_n   = ST_HDR_R;
               end else begin
                  st_n = ST_FAIL;
               end
            end
         end
         ST_HDR_R: begin
            if (g_filled) begin
               if (!v_ok) begin
                  st_n = ST_FAIL;
               end else if (nm_q == '0 || v_val == '0) begin
                  st_n = ST_DONE;
               end else begin
                  st_n = ST_SETUP;
               end
            end
         end
         ST_SETUP: st_n = ST_ISSUE;
         ST_ISSUE: begin
            g_go     = 1'b1;
            g_base   = AW'(HDR_OFS) + AW'(off_q);
            g_stride = AW'(set_q) << 1;
            st_n     = ST_PLAIN;
         end
         ST_PLAIN: begin
            if (g_filled) begin
               if (v_ok) begin
                  wr   = 1'b1;
                  st_n = last_ent ? ST_DONE : ST_ISSUE;
               end else begin
                  g_go     = 1'b1;
                  g_base   = AW'(HDR_OFS) + AW'(set_q) + AW'(off_q);
                  g_stride = AW'(set_q) << 1;
                  st_n     = ST_INV;
               end
            end
         end
         ST_INV: begin
            if (g_filled) begin
               if (v_ok) begin
                  wr      = 1'b1;
                  wr_data = ~v_val;
                  st_n    = last_ent ? ST_DONE : ST_ISSUE;
               end else begin
                  st_n = ST_FAIL;
               end
            end
         end
         ST_DONE: st_n = ST_IDLE;
         ST_FAIL: st_n = ST_IDLE;
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         nm_q     <= '0;
         nr_q     <= '0;
         set_q    <= '0;
         off_q    <= '0;
         tbl_we   <= 1'b0;
         tbl_addr <= '0;
         tbl_data <= '0;
      end else begin
         st_q   <= st_n;
         tbl_we <= wr;
         if (st_q == ST_IDLE && start) begin
            nm_q <= '0;
            nr_q <= '0;
         end
         if (st_q == ST_HDR_M && g_filled && v_ok) begin
            nm_q <= v_val;
         end
         if (st_q == ST_HDR_R && g_filled && v_ok) begin
            nr_q <= v_val;
         end
         if (st_q == ST_SETUP) begin
            set_q <= TW'(nm_q) * TW'(nr_q);
            off_q <= '0;
         end
         if (wr) begin
            tbl_addr <= off_q;
            tbl_data <= wr_data;
            off_q    <= off_q + TW'(1);
         end
      end
   end

   assign busy       = (st_q != ST_IDLE) && (st_q != ST_DONE) && (st_q != ST_FAIL);
   assign done       = (st_q == ST_DONE);
   assign fail       = (st_q == ST_FAIL);
   assign mode_count = nm_q;
   assign reg_count  = nr_q;

endmodule

// File: rtl/rcv_checker.sv
module rcv_checker #(
   parameter int TW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic          fail,
   input logic          mem_re,
   input logic          tbl_we,
   input logic [TW-1:0] tbl_addr
);
   logic          seen_q;
   logic [TW-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         prev_q <= '0;
      end else if (start && !busy && !done && !fail) begin
         seen_q <= 1'b0;
      end else if (tbl_we) begin
         seen_q <= 1'b1;
         prev_q <= tbl_addr;
      end
   end

   AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail)); // R9
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      fail |=> !tbl_we); // R6
   AST_WE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_we |-> (busy || done)); // R8
   AST_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |-> busy); // R11
   AST_ADDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_we && !seen_q) |-> (tbl_addr == '0)); // R8
   AST_ADDR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_we && seen_q) |-> (tbl_addr == prev_q + TW'(1))); // R8
   AST_RUN_ENDS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy || done || fail)); // R12

endmodule

bind rcopy_vote_extract rcv_checker #(.TW(TW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .fail     (fail),
   .mem_re   (mem_re),
   .tbl_we   (tbl_we),
   .tbl_addr (tbl_addr)
);

// File: tb/sim_rcopy_vote_extract.sv
module sim_rcopy_vote_extract;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 21;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic busy, done, fail, mem_re, tbl_we;
   logic [AW-1:0] mem_addr;
   logic [7:0] mem_rdata = 8'h00;
   logic [15:0] tbl_addr;
   logic [7:0] tbl_data, mode_count, reg_count;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rcopy_vote_extract u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .fail(fail), .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
      .mode_count(mode_count), .reg_count(reg_count)
   );

   logic [7:0] mem [256];
   always @(posedge clk) if (mem_re) mem_rdata <= mem[mem_addr[7:0]];

   int checks = 0;
   int errs = 0;

   int got_n, rd_n, re_idle, re_far, done_n;
   logic [15:0] got_addr [64];
   logic [7:0]  got_data [64];
   int          rd_log [256];

   always @(negedge clk) begin
      if (tbl_we && got_n < 64) begin
         got_addr[got_n] = tbl_addr;
         got_data[got_n] = tbl_data;
         got_n++;
      end
      if (mem_re) begin
         if (rd_n < 256) rd_log[rd_n] = int'(mem_addr);
         rd_n++;
         if (!busy) re_idle++;
         if (mem_addr[AW-1:8] != '0) re_far++;
      end
      if (done) done_n++;
   end

   task automatic chk(input bit cond, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!cond) begin
         errs++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Vote by the stated rule: candidates 0..3, more than 4 later matches.
   function automatic logic [8:0] gv(input logic [63:0] c);
      for (int i = 0; i < 4; i++) begin
         int n = 0;
         for (int j = i + 1; j < 8; j++)
            if (c[8*j +: 8] == c[8*i +: 8]) n++;
         if (n > 4) return {1'b1, c[8*i +: 8]};
      end
      return 9'h000;
   endfunction

   function automatic logic [63:0] col(input int base, input int stride);
      logic [63:0] r;
      for (int k = 0; k < 8; k++) r[8*k +: 8] = mem[(base + k*stride) % 256];
      return r;
   endfunction

   int         e_fail, e_n, e_hdrfail, e_set;
   logic [7:0] e_nm, e_nr;
   logic [7:0] e_data [64];

   task automatic expect_run();
      logic [8:0] r, q;
      e_fail = 0; e_n = 0; e_hdrfail = 0; e_set = 0; e_nm = 0; e_nr = 0;
      r = gv(col(0, 1));
      if (!r[8]) begin e_fail = 1; e_hdrfail = 1; return; end
      e_nm = r[7:0];
      r = gv(col(8, 1));
      if (!r[8]) begin e_fail = 1; e_hdrfail = 2; return; end
      e_nr = r[7:0];
      e_set = int'(e_nm) * int'(e_nr);
      for (int e = 0; e < e_set; e++) begin
         q = gv(col(16 + e, 2*e_set));
         if (q[8]) e_data[e_n++] = q[7:0];
         else begin
            q = gv(col(16 + e_set + e, 2*e_set));
            if (q[8]) e_data[e_n++] = ~q[7:0];
            else begin e_fail = 1; return; end
         end
      end
   endtask

   // Fill the buffer; corrupted copies get distinct values (no false majority).
   task automatic build(input int nm, input int nr, input int seed,
                        input int bad_e, input int pbad, input int ibad,
                        input bit tail, input int hmbad, input int hrbad);
      int set;
      for (int a = 0; a < 256; a++) mem[a] = 8'(a * 13 + seed);
      for (int k = 0; k < 8; k++) begin
         mem[k]     = 8'(nm) ^ ((k < hmbad) ? 8'(k + 1) : 8'h00);
         mem[8 + k] = 8'(nr) ^ ((k < hrbad) ? 8'(k + 1) : 8'h00);
      end
      set = nm * nr;
      for (int e = 0; e < set; e++) begin
         logic [7:0] v = 8'(e * 29 + seed * 7 + 3);
         for (int c = 0; c < 8; c++) begin
            int pos = tail ? (7 - c) : c;
            bit pb = (e == bad_e) && (pos < pbad);
            bit ib = (e == bad_e) && (pos < ibad);
            mem[16 + 2*c*set + e]     = pb ? (v ^ 8'(c + 1)) : v;
            mem[16 + (2*c+1)*set + e] = ib ? (~v ^ 8'(c + 1)) : ~v;
         end
      end
   endtask

   task automatic run(input string tag, input bit midstart);
      int cyc = 0;
      expect_run();
      got_n = 0; rd_n = 0; re_idle = 0; re_far = 0; done_n = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      while (!(done || fail) && cyc < 20000) begin
         start = (midstart && cyc == 40) ? 1'b1 : 1'b0;
         @(negedge clk);
         cyc++;
      end
      start = midstart ? 1'b1 : 1'b0;    // R12: start during done/fail cycle
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      chk(fail == 1'b0 && done == 1'b0 && busy == 1'b0, "R12", {tag, " idle after end"}, busy, 0);
      chk((e_fail != 0) == (done_n == 0), "R6", {tag, " outcome"}, done_n, e_fail ? 0 : 1);
      chk(got_n == e_n, "R8", {tag, " write count"}, got_n, e_n);
      for (int i = 0; i < e_n && i < got_n; i++) begin
         chk(got_addr[i] == 16'(i), "R8", {tag, " addr"}, got_addr[i], i);
         chk(got_data[i] == e_data[i], "R5", {tag, " data"}, got_data[i], e_data[i]);
      end
      chk(re_idle == 0 && re_far == 0, "R11", {tag, " read window"}, re_idle + re_far, 0);
      if (e_hdrfail == 1) chk(rd_n == 8, "R7", {tag, " reads"}, rd_n, 8);
      if (e_hdrfail == 2) chk(rd_n == 16, "R7", {tag, " reads"}, rd_n, 16);
      if (e_hdrfail == 0) begin
         chk(mode_count == e_nm && reg_count == e_nr, "R2", {tag, " counts"},
             {mode_count, reg_count}, {e_nm, e_nr});
         for (int k = 0; k < 16; k++)
            chk(rd_log[k] == k, "R2", {tag, " header addr"}, rd_log[k], k);
         if (e_set > 0)
            for (int c = 0; c < 8; c++)
               chk(rd_log[16 + c] == 16 + 2*c*e_set, "R4", {tag, " copy addr"},
                   rd_log[16 + c], 16 + 2*c*e_set);
      end
      if (e_set == 0 && e_fail == 0) chk(got_n == 0 && done_n == 1, "R10", {tag, " empty"}, got_n, 0);
   endtask

   initial begin
      repeat (1000000) @(posedge clk);
      checks++; errs++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - errs, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !fail && !tbl_we && !mem_re, "R1", "reset state",
          {busy, done, fail, tbl_we, mem_re}, 0);

      // R2 R4 R8: sweep of table shapes, all copies clean
      for (int nm = 1; nm <= 4; nm++)
         for (int nr = 1; nr <= 3; nr++) begin
            build(nm, nr, nm * 5 + nr, -1, 0, 0, 1'b0, 0, 0);
            run("sweep", 1'b0);
         end
      // R3: exactly six agree (head or tail disagree) -> plain accepted
      build(3, 2, 11, 2, 2, 8, 1'b0, 0, 0); run("R3 six head", 1'b0);
      build(3, 2, 12, 4, 2, 8, 1'b1, 0, 0); run("R3 six tail", 1'b0);
      // R5: plain has only five -> inverted fallback, complemented
      build(2, 3, 13, 1, 3, 0, 1'b0, 0, 0); run("R5 inv", 1'b0);
      build(2, 3, 14, 5, 3, 2, 1'b1, 0, 0); run("R5 inv tail", 1'b0);
      // R6: both votes fail mid-table
      build(3, 3, 15, 4, 3, 3, 1'b0, 0, 0); run("R6 entry fail", 1'b0);
      build(2, 2, 16, 0, 8, 3, 1'b1, 0, 0); run("R6 first fail", 1'b0);
      // R7: header failures; six-agree header accepted
      build(2, 2, 17, -1, 0, 0, 1'b0, 3, 0); run("R7 modes", 1'b0);
      build(2, 2, 18, -1, 0, 0, 1'b0, 0, 3); run("R7 regs", 1'b0);
      build(2, 2, 19, -1, 0, 0, 1'b0, 2, 2); run("R3 header six", 1'b0);
      // R10: zero counts
      build(3, 0, 20, -1, 0, 0, 1'b0, 0, 0); run("R10 regs0", 1'b0);
      build(0, 3, 21, -1, 0, 0, 1'b0, 0, 0); run("R10 modes0", 1'b0);
      // R12: start pulses mid-run and in the end cycle are ignored
      build(4, 3, 22, -1, 0, 0, 1'b0, 0, 0); run("R12 restart", 1'b1);
      build(2, 2, 23, 1, 3, 3, 1'b0, 0, 0); run("R12 restart fail", 1'b1);

      $display("%0d/%0d checks passed", checks - errs, checks);
      $finish;
   end

endmodule